// File: doc/BRIEF.md
# Packed Single-Precision Predicate Comparator

This block compares two vectors of four IEEE-754 single-precision lanes. Each lane is classified into exactly one relation: unordered (one or both operands NaN), less, greater or equal. A 4-bit predicate lists the relations that count as true. Each lane's result is then all ones or all zeros. Ordered tests, unordered tests and every mixed condition, such as "unordered or not equal", come from the same mechanism.

A NaN operand can raise an invalid-operation flag. A signalling NaN always raises it. A quiet NaN raises it only when the caller asks for the signalling flavour of the compare. The flag is sticky until an explicit clear and never changes the result mask. A single-cycle `in_valid` strobe launches a compare. The mask, `out_valid` and the flag update all appear on the next clock edge.

Top module: `fpcmp_packed`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `out_valid`=0, `out_mask`=0 and `invalid_flag`=0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_mask` holds its value when `in_valid` is low.
- R3: Lane i occupies bits [32i+31:32i] of the operands and of `out_mask`. Each lane is evaluated on its own. The lane result is 0xFFFFFFFF when the predicate bit of the lane's relation is set, and 0x00000000 otherwise. The predicate bits are [3]=unordered, [2]=less (a<b), [1]=greater (a>b), [0]=equal.
- R4: An operand with exponent 0xFF and a non-zero mantissa is a NaN. A lane with any NaN operand has the unordered relation, NaN against itself included. So predicate 0111 is false for that lane and 1000 is true.
- R5: +0 and -0 compare equal.
- R6: Operands that are not NaN are ordered by value. Any negative value is below any positive value. Between two negatives the larger magnitude is the smaller value. Infinities sit beyond every finite value.
- R7: On a valid compare, a signalling NaN (mantissa bit 22 clear) in any operand of any lane sets `invalid_flag`, whatever `sig_qnan` is.
- R8: On a valid compare, a quiet NaN (mantissa bit 22 set) sets `invalid_flag` only when `sig_qnan` is 1.
- R9: `invalid_flag` stays set until `flag_clr` is high at an edge. A raising compare in the same cycle as `flag_clr` leaves the flag set. The flag has no effect on `out_mask`. Inputs with `in_valid` low never raise it.
- R10: Predicate 0000 gives all-zero lanes and 1111 gives all-one lanes, NaN operands included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Launches a compare this cycle |
| op_a | input | 128 | First operand vector, four single-precision lanes |
| op_b | input | 128 | Second operand vector |
| pred | input | 4 | Relation mask {unordered, less, greater, equal} |
| sig_qnan | input | 1 | Quiet NaNs also raise the invalid flag |
| flag_clr | input | 1 | Clears the sticky invalid flag |
| out_valid | output | 1 | Result registered from last cycle's compare |
| out_mask | output | 128 | Per-lane all-ones / all-zeros result |
| invalid_flag | output | 1 | Sticky invalid-operation flag |

## Verification
The bound checker watches several properties on every cycle. Each lane's classification must be exactly one relation. Every lane of the mask must be uniform. The strobe-to-valid timing, the hold of the mask while idle, the stickiness of the flag and its rise only after a valid compare are checked, along with the trivially false and true predicates. Whether the chosen relation is the right one for given numbers can only be shown by the bench. Its scenarios cover signed zeros, negative ordering, infinities and NaN sign and payload variants, lanes holding different relations in one vector, and the quiet/signalling flag behaviour with a clear in the same cycle.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int FP_W  = 32;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int QBIT  = MAN_W - 1;

  localparam int REL_U = 3;
  localparam int REL_L = 2;
  localparam int REL_G = 1;
  localparam int REL_E = 0;

  function automatic logic fp_is_nan(input logic [FP_W-1:0] x);
    return (&x[FP_W-2 -: EXP_W]) && (|x[MAN_W-1:0]);
  endfunction

  function automatic logic fp_is_snan(input logic [FP_W-1:0] x);
    return fp_is_nan(x) && !x[QBIT];
  endfunction

  function automatic logic fp_is_qnan(input logic [FP_W-1:0] x);
    return fp_is_nan(x) && x[QBIT];
  endfunction

  // One-hot relation of a against b, indexed by REL_*.
  function automatic logic [3:0] fp_relation(input logic [FP_W-1:0] a,
                                             input logic [FP_W-1:0] b);
    logic [3:0] r;
    logic mag_lt, lt;
    r = '0;
    mag_lt = a[FP_W-2:0] < b[FP_W-2:0];
    if (fp_is_nan(a) || fp_is_nan(b)) begin
      r[REL_U] = 1'b1;
    end else if (a == b || (~|a[FP_W-2:0] && ~|b[FP_W-2:0])) begin
      r[REL_E] = 1'b1;
    end else begin
      if (a[FP_W-1] != b[FP_W-1]) lt = a[FP_W-1];
      else                        lt = a[FP_W-1] ? !mag_lt : mag_lt;
      if (lt) r[REL_L] = 1'b1;
      else    r[REL_G] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/fpcmp_lane.sv
module fpcmp_lane
  import fpcmp_pkg::*;
(
  input  logic [FP_W-1:0] a,
  input  logic [FP_W-1:0] b,
  input  logic [3:0]      pred,
  input  logic            sig_qnan,
  output logic [3:0]      rel,
  output logic            hit,
  output logic            raise
);
  logic snan_any, qnan_any;

  always_comb begin
    rel      = fp_relation(a, b);
    hit      = |(rel & pred);
    snan_any = fp_is_snan(a) || fp_is_snan(b);
    qnan_any = fp_is_qnan(a) || fp_is_qnan(b);
    raise    = snan_any || (sig_qnan && qnan_any);
  end
endmodule

// File: rtl/fpcmp_sticky.sv
module fpcmp_sticky (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= (flag && !clr) || set;
  end
endmodule

// File: rtl/fpcmp_packed.sv
module fpcmp_packed
  import fpcmp_pkg::*;
#(
  parameter int LANES = 4,
  localparam int VEC_W = LANES * FP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  input  logic [3:0]       pred,
  input  logic             sig_qnan,
  input  logic             flag_clr,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_mask,
  output logic             invalid_flag
);
  logic [LANES-1:0][3:0] lane_rel;
  logic [LANES-1:0]      lane_hit;
  logic [LANES-1:0]      lane_raise;
  logic                  raise_evt;
  logic [VEC_W-1:0]      mask_next;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    fpcmp_lane u_lane (
      .a        (op_a[i*FP_W +: FP_W]),
      .b        (op_b[i*FP_W +: FP_W]),
      .pred     (pred),
      .sig_qnan (sig_qnan),
      .rel      (lane_rel[i]),
      .hit      (lane_hit[i]),
      .raise    (lane_raise[i])
    );
    assign mask_next[i*FP_W +: FP_W] = {FP_W{lane_hit[i]}};
  end

  assign raise_evt = in_valid && (|lane_raise);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_mask <= mask_next;
    end
  end

  fpcmp_sticky u_flag (
    .clk  (clk),
    .rst  (rst),
    .clr  (flag_clr),
    .set  (raise_evt),
    .flag (invalid_flag)
  );
endmodule

// File: rtl/fpcmp_packed_sva.sv
module fpcmp_packed_sva
  import fpcmp_pkg::*;
#(
  parameter int LANES = 4,
  localparam int VEC_W = LANES * FP_W
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [3:0]            pred,
  input logic                  flag_clr,
  input logic                  out_valid,
  input logic [VEC_W-1:0]      out_mask,
  input logic                  invalid_flag,
  input logic [LANES-1:0][3:0] lane_rel,
  input logic                  raise_evt
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !invalid_flag && out_mask == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_mask));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assert_one_relation_R4: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> $countones(lane_rel[i]) == 1);

    assert_lane_uniform_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_mask[i*FP_W +: FP_W] == '0 || out_mask[i*FP_W +: FP_W] == '1));
  end

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (invalid_flag && !flag_clr) |=> invalid_flag);

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !raise_evt) |=> !invalid_flag);

  assert_flag_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(invalid_flag) |-> $past(in_valid));

  assert_raise_sets_R7: assert property (@(posedge clk) disable iff (rst)
    raise_evt |=> invalid_flag);

  assert_never_true_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pred == 4'b0000) |=> out_mask == '0);

  assert_always_true_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pred == 4'b1111) |=> out_mask == '1);
endmodule

bind fpcmp_packed fpcmp_packed_sva #(.LANES(LANES)) u_sva (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .pred         (pred),
  .flag_clr     (flag_clr),
  .out_valid    (out_valid),
  .out_mask     (out_mask),
  .invalid_flag (invalid_flag),
  .lane_rel     (lane_rel),
  .raise_evt    (raise_evt)
);

// File: tb/fpcmp_packed_tb.sv
module fpcmp_packed_tb;
  localparam int LANES = 4;
  localparam int VW    = 32 * LANES;
  localparam int NV    = 24;

  // {a, b, pred, sig_qnan, expected lane true, expected flag}
  localparam logic [70:0] VEC [NV] = '{
    {32'h3F800000, 32'h40000000, 4'b0100, 1'b0, 1'b1, 1'b0}, // R6 1<2 less
    {32'h3F800000, 32'h40000000, 4'b0010, 1'b0, 1'b0, 1'b0}, // R3 1>2 false
    {32'h40000000, 32'h3F800000, 4'b0010, 1'b0, 1'b1, 1'b0}, // R6 2>1
    {32'hBF800000, 32'hC0000000, 4'b0010, 1'b0, 1'b1, 1'b0}, // R6 -1>-2
    {32'hC0000000, 32'hBF800000, 4'b0100, 1'b0, 1'b1, 1'b0}, // R6 -2<-1
    {32'hBF800000, 32'h3F800000, 4'b0100, 1'b0, 1'b1, 1'b0}, // R6 -1<1
    {32'h00000000, 32'h80000000, 4'b0001, 1'b0, 1'b1, 1'b0}, // R5 +0==-0
    {32'h80000000, 32'h00000000, 4'b0100, 1'b0, 1'b0, 1'b0}, // R5 -0 not < +0
    {32'h7FC00000, 32'h3F800000, 4'b0111, 1'b0, 1'b0, 1'b0}, // R4 ordered false
    {32'h7FC00000, 32'h3F800000, 4'b1000, 1'b0, 1'b1, 1'b0}, // R4 unordered true
    {32'h7FC00000, 32'h7FC00000, 4'b0001, 1'b0, 1'b0, 1'b0}, // R4 NaN!=NaN
    {32'h7FC00000, 32'h7FC00000, 4'b1000, 1'b0, 1'b1, 1'b0}, // R4 NaN vs itself
    {32'h7FC00000, 32'h3F800000, 4'b1000, 1'b1, 1'b1, 1'b1}, // R8 qNaN signalling
    {32'h7F800001, 32'h3F800000, 4'b0111, 1'b0, 1'b0, 1'b1}, // R7 sNaN quiet mode
    {32'h3F800000, 32'hFF800001, 4'b0000, 1'b0, 1'b0, 1'b1}, // R10 false, R7 flag
    {32'h7FC00000, 32'h40000000, 4'b1111, 1'b0, 1'b1, 1'b0}, // R10 true with NaN
    {32'hFF800000, 32'h7F800000, 4'b0100, 1'b0, 1'b1, 1'b0}, // R6 -inf<+inf
    {32'h7F800000, 32'h7F7FFFFF, 4'b0010, 1'b0, 1'b1, 1'b0}, // R6 inf>max
    {32'h3F800000, 32'h3F800000, 4'b0111, 1'b1, 1'b1, 1'b0}, // R8 no NaN no flag
    {32'h3F800000, 32'h3F800000, 4'b1110, 1'b0, 1'b0, 1'b0}, // R3 unord-or-ne
    {32'h7FC00000, 32'h3F800000, 4'b1110, 1'b0, 1'b1, 1'b0}, // R3 unord-or-ne NaN
    {32'h3F800000, 32'h3F800000, 4'b1001, 1'b0, 1'b1, 1'b0}, // R3 unord-or-eq
    {32'hFFC00001, 32'h3F800000, 4'b1000, 1'b0, 1'b1, 1'b0}, // R4 negative qNaN
    {32'h3F800000, 32'hFFC00000, 4'b0111, 1'b1, 1'b0, 1'b1}  // R8 qNaN in b
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [VW-1:0] op_a = '0;
  logic [VW-1:0] op_b = '0;
  logic [3:0]    pred = '0;
  logic          sig_qnan = 1'b0;
  logic          flag_clr = 1'b0;
  logic          out_valid;
  logic [VW-1:0] out_mask;
  logic          invalid_flag;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fpcmp_packed #(.LANES(LANES)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .pred(pred), .sig_qnan(sig_qnan), .flag_clr(flag_clr),
    .out_valid(out_valid), .out_mask(out_mask), .invalid_flag(invalid_flag)
  );

  task automatic check(input string req, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one compare at a falling edge, sample after the next rising edge.
  task automatic launch(input logic [VW-1:0] a, input logic [VW-1:0] b,
                        input logic [3:0] p, input logic sq, input logic clr);
    @(negedge clk);
    op_a = a; op_b = b; pred = p; sig_qnan = sq; flag_clr = clr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid", VW'(out_valid), '0);
    check("R1 out_mask", out_mask, '0);
    check("R1 invalid_flag", VW'(invalid_flag), '0);
    rst = 1'b0;

    // Table: same vector in every lane, flag cleared in the same cycle.
    for (int k = 0; k < NV; k++) begin
      logic [31:0] a, b;
      a = VEC[k][70:39];
      b = VEC[k][38:7];
      launch({LANES{a}}, {LANES{b}}, VEC[k][6:3], VEC[k][2], 1'b1);
      check($sformatf("R2 valid vec%0d", k), VW'(out_valid), VW'(1));
      check($sformatf("R3 mask vec%0d", k), out_mask, {VW{VEC[k][1]}});
      check($sformatf("R9 flag vec%0d", k), VW'(invalid_flag), VW'(VEC[k][0]));
    end

    // R3: lanes independent; pred less. lane0 1<2, lane1 2>1, lane2 NaN, lane3 0,-0
    launch({32'h00000000, 32'h7FC00000, 32'h40000000, 32'h3F800000},
           {32'h80000000, 32'h3F800000, 32'h3F800000, 32'h40000000},
           4'b0100, 1'b0, 1'b1);
    check("R3 mixed lanes less", out_mask,
          {32'h0, 32'h0, 32'h0, 32'hFFFFFFFF});
    launch({32'h00000000, 32'h7FC00000, 32'h40000000, 32'h3F800000},
           {32'h80000000, 32'h3F800000, 32'h3F800000, 32'h40000000},
           4'b1001, 1'b0, 1'b0);
    check("R3 mixed lanes unord-or-eq", out_mask,
          {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0});

    // R7/R9: sNaN in lane 3 only sets the flag; it sticks across a clean compare.
    launch({32'h7F800010, {3{32'h3F800000}}}, {4{32'h3F800000}}, 4'b0001, 1'b0, 1'b0);
    check("R7 snan lane3 flag", VW'(invalid_flag), VW'(1));
    check("R7 snan lane3 mask", out_mask, {32'h0, {3{32'hFFFFFFFF}}});
    launch({4{32'h3F800000}}, {4{32'h40000000}}, 4'b0100, 1'b0, 1'b0);
    check("R9 flag sticky", VW'(invalid_flag), VW'(1));
    check("R9 flag no effect on mask", out_mask, '1);

    // R2/R9: idle cycle with clear only; mask holds, flag drops.
    @(negedge clk);
    flag_clr = 1'b1;
    op_a = {4{32'h7F800001}}; pred = 4'b1111;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R9 clear", VW'(invalid_flag), '0);
    check("R2 no valid", VW'(out_valid), '0);
    check("R2 mask held", out_mask, '1);

    // R9: sNaN presented without in_valid raises nothing.
    @(negedge clk);
    @(negedge clk);
    check("R9 idle no raise", VW'(invalid_flag), '0);

    // R8: qNaN with quiet flavour leaves the flag clear.
    launch({4{32'h7FC00000}}, {4{32'h7FC00000}}, 4'b0111, 1'b0, 1'b0);
    check("R8 quiet qnan no flag", VW'(invalid_flag), '0);
    check("R8 quiet qnan mask", out_mask, '0);

    // R1: reset mid-run.
    launch({4{32'h7F800001}}, {4{32'h0}}, 4'b1000, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset flag", VW'(invalid_flag), '0);
    check("R1 reset mask", out_mask, '0);
    rst = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule